// File: doc/BRIEF.md
# Identification and Status Readback Window

This block answers byte reads on the save-memory bus while the cartridge controller is in its identification mode. In that mode the 16-bit bus offset selects one of several items. A five-byte signature identifies the controller. Two 6-bit voltage codes give the battery and host supply levels. Six 16-bit control and bank registers are presented one bit at a time. A 1 KB scratch cache can be read and written one byte at a time.

The register values come from the command decoder, and the voltage codes come from the measurement logic. Both arrive as plain inputs. Outside identification mode the block answers nothing and raises a select flag, so that the access goes to the ordinary save memory. Read data is registered and appears one clock after the read is presented.

Top module: `idwin_readback`

## Requirements
- R1: In identification mode, reads at offsets 0x0000, 0x0001, 0x0002, 0x0003 and 0x0004 return 0x34, 0x16, 0x96, 0x24 and 0xF6 respectively.
- R2: In identification mode, offset 0x0005 returns the battery code and offset 0x0006 returns the host supply code, each zero-extended from 6 bits to 8 bits (code 0 means 0.8 V or less, code 63 means 3.3 V).
- R3: Six register slots of sixteen addresses each are mapped as follows: extended control at 0x8040, save device identifier at 0x8050, main control at 0x8070, I/O control at 0x8080, ROM bank at 0x8090 and save bank at 0x80A0. A read of slot base + n returns bit n of that register in data bit 0.
- R4: A read from a register slot returns 0 in data bits 7 to 1.
- R5: Offsets 0xC000 to 0xC3FF address a 1 KB cache by offset bits 9:0. A write stores its byte at the clock edge where the strobe is sampled, and a later read returns that byte.
- R6: `rd_data` changes only at the clock edge that samples `rd_en` high, and shows the item selected by the offset presented in that cycle. While `rd_en` is low it holds its value.
- R7: While `id_mode` is low, `ext_sram_sel` is 1 whenever `rd_en` or `wr_en` is 1, and 0 otherwise. A read in that state loads 0x00, and a write leaves the cache unchanged. `ext_sram_sel` is 0 whenever `id_mode` is 1.
- R8: In identification mode, offsets outside R1, R2, R3 and R5 read as 0x00 (for example 0x0007, 0x8060, 0x80B0 and 0xC400). Writes to them leave the cache unchanged, including offsets whose low ten bits match a cache entry.
- R9: After reset, `rd_data` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| id_mode | input | 1 | Identification mode active |
| bus_offset | input | 16 | Byte offset on the save-memory bus |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write byte |
| ctrl_ext | input | 16 | Extended control register value |
| save_dev_id | input | 16 | Save memory device identifier |
| ctrl_main | input | 16 | Main control register value |
| io_ctrl | input | 16 | I/O control register value |
| rom_bank | input | 16 | ROM bank register value |
| save_bank | input | 16 | Save bank register value |
| batt_code | input | 6 | Battery voltage code |
| host_code | input | 6 | Host supply voltage code |
| rd_data | output | 8 | Registered read data |
| ext_sram_sel | output | 1 | Access belongs to ordinary save memory |

## Verification
The hardest case to reach is a write that must not land in the cache. This covers writes made outside identification mode, and writes to offsets such as 0xC400 whose low ten bits equal a real cache address. Such a write has no visible effect of its own. To expose it, the bench first fills the aliased cache bytes with known values. It then issues the stray writes with different data, re-enters identification mode, and reads the cache bytes back. Any leak shows up as a changed byte.

// File: rtl/idwin_pkg.sv
package idwin_pkg;

    typedef enum logic [2:0] {
        RG_NONE  = 3'd0,
        RG_SIG   = 3'd1,
        RG_VBATT = 3'd2,
        RG_VHOST = 3'd3,
        RG_SLOT  = 3'd4,
        RG_CACHE = 3'd5
    } region_e;

    localparam int NSLOT   = 6;
    localparam int SLOT_IW = 3;
    localparam int SIG_LEN = 5;

    // slot order: ext ctrl, dev id, main ctrl, io ctrl, rom bank, save bank
    localparam logic [3:0] SLOT_NIB [NSLOT] = '{4'h4, 4'h5, 4'h7, 4'h8, 4'h9, 4'hA};
    localparam logic [7:0] SLOT_PAGE = 8'h80;

    localparam logic [15:0] VBATT_OFFS = 16'h0005;
    localparam logic [15:0] VHOST_OFFS = 16'h0006;

    function automatic logic [7:0] sig_byte(input logic [2:0] idx);
        logic [7:0] b;
        case (idx)
            3'd0:    b = 8'h34;
            3'd1:    b = 8'h16;
            3'd2:    b = 8'h96;
            3'd3:    b = 8'h24;
            3'd4:    b = 8'hF6;
            default: b = 8'h00;
        endcase
        return b;
    endfunction

    typedef struct packed {
        logic [7:0] val;
        logic       from_cache;
    } rd_state_t;

endpackage

// File: rtl/idwin_decode.sv
module idwin_decode
    import idwin_pkg::*;
#(
    parameter int OFFS_W     = 16,
    parameter int CACHE_AW   = 10,
    parameter logic [15:0] CACHE_BASE = 16'hC000
) (
    input  logic [OFFS_W-1:0]   offset,
    output region_e             region,
    output logic [SLOT_IW-1:0]  slot_idx,
    output logic [3:0]          bit_idx,
    output logic [CACHE_AW-1:0] cache_addr,
    output logic [2:0]          sig_idx
);
    logic [NSLOT-1:0] slot_hit;
    logic             page_hit;

    assign page_hit = (offset[15:8] == SLOT_PAGE);

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        assign slot_hit[s] = page_hit && (offset[7:4] == SLOT_NIB[s]);
    end

    always_comb begin
        slot_idx = '0;
        for (int s = 0; s < NSLOT; s++) begin
            if (slot_hit[s]) slot_idx = SLOT_IW'(s);
        end
    end

    assign bit_idx    = offset[3:0];
    assign cache_addr = offset[CACHE_AW-1:0];
    assign sig_idx    = offset[2:0];

    always_comb begin
        region = RG_NONE;
        if (offset < OFFS_W'(SIG_LEN))
            region = RG_SIG;
        else if (offset == VBATT_OFFS)
            region = RG_VBATT;
        else if (offset == VHOST_OFFS)
            region = RG_VHOST;
        else if (|slot_hit)
            region = RG_SLOT;
        else if (offset[OFFS_W-1:CACHE_AW] == CACHE_BASE[OFFS_W-1:CACHE_AW])
            region = RG_CACHE;
    end

    always_comb begin
        assert ($onehot0(slot_hit)) else $error("slot decode overlap (R3)");
    end
endmodule

// File: rtl/idwin_regslot.sv
module idwin_regslot
    import idwin_pkg::*;
#(
    parameter int REG_W = 16
) (
    input  logic [NSLOT-1:0][REG_W-1:0] regs,
    input  logic [SLOT_IW-1:0]          slot_idx,
    input  logic [3:0]                  bit_idx,
    output logic                        bit_out
);
    logic [REG_W-1:0] sel_reg;

    always_comb begin
        sel_reg = '0;
        for (int s = 0; s < NSLOT; s++) begin
            if (slot_idx == SLOT_IW'(s)) sel_reg = regs[s];
        end
        bit_out = sel_reg[bit_idx];
    end
endmodule

// File: rtl/idwin_cache.sv
module idwin_cache #(
    parameter int DEPTH  = 1024,
    parameter int DATA_W = 8,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              re,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        if (re) rdata <= mem[raddr];
    end
endmodule

// File: rtl/idwin_readback.sv
module idwin_readback
    import idwin_pkg::*;
#(
    parameter int OFFS_W      = 16,
    parameter int DATA_W      = 8,
    parameter int REG_W       = 16,
    parameter int VCODE_W     = 6,
    parameter int CACHE_BYTES = 1024,
    localparam int CACHE_AW   = $clog2(CACHE_BYTES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               id_mode,
    input  logic [OFFS_W-1:0]  bus_offset,
    input  logic               rd_en,
    input  logic               wr_en,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic [REG_W-1:0]   ctrl_ext,
    input  logic [REG_W-1:0]   save_dev_id,
    input  logic [REG_W-1:0]   ctrl_main,
    input  logic [REG_W-1:0]   io_ctrl,
    input  logic [REG_W-1:0]   rom_bank,
    input  logic [REG_W-1:0]   save_bank,
    input  logic [VCODE_W-1:0] batt_code,
    input  logic [VCODE_W-1:0] host_code,
    output logic [DATA_W-1:0]  rd_data,
    output logic               ext_sram_sel
);
    region_e                    region;
    logic [SLOT_IW-1:0]         slot_idx;
    logic [3:0]                 bit_idx;
    logic [CACHE_AW-1:0]        cache_addr;
    logic [2:0]                 sig_idx;
    logic                       slot_bit;
    logic [NSLOT-1:0][REG_W-1:0] regs;
    logic [DATA_W-1:0]          ram_q;
    logic                       cache_we, cache_re;
    rd_state_t                  st_d, st_q;

    assign regs = {save_bank, rom_bank, io_ctrl, ctrl_main, save_dev_id, ctrl_ext};

    idwin_decode #(
        .OFFS_W   (OFFS_W),
        .CACHE_AW (CACHE_AW)
    ) u_decode (
        .offset     (bus_offset),
        .region     (region),
        .slot_idx   (slot_idx),
        .bit_idx    (bit_idx),
        .cache_addr (cache_addr),
        .sig_idx    (sig_idx)
    );

    idwin_regslot #(.REG_W(REG_W)) u_regslot (
        .regs     (regs),
        .slot_idx (slot_idx),
        .bit_idx  (bit_idx),
        .bit_out  (slot_bit)
    );

    assign cache_we = wr_en && id_mode && (region == RG_CACHE);
    assign cache_re = rd_en && id_mode && (region == RG_CACHE);

    idwin_cache #(.DEPTH(CACHE_BYTES), .DATA_W(DATA_W)) u_cache (
        .clk   (clk),
        .we    (cache_we),
        .waddr (cache_addr),
        .wdata (wr_data),
        .re    (cache_re),
        .raddr (cache_addr),
        .rdata (ram_q)
    );

    always_comb begin
        st_d = st_q;
        if (rd_en) begin
            st_d.val        = '0;
            st_d.from_cache = 1'b0;
            if (id_mode) begin
                case (region)
                    RG_SIG:   st_d.val = sig_byte(sig_idx);
                    RG_VBATT: st_d.val = {{(DATA_W-VCODE_W){1'b0}}, batt_code};
                    RG_VHOST: st_d.val = {{(DATA_W-VCODE_W){1'b0}}, host_code};
                    RG_SLOT:  st_d.val = {{(DATA_W-1){1'b0}}, slot_bit};
                    RG_CACHE: st_d.from_cache = 1'b1;
                    default:  st_d.val = '0;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_data      = st_q.from_cache ? ram_q : st_q.val;
    assign ext_sram_sel = !id_mode && (rd_en || wr_en);

    p_sig_first_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && id_mode && bus_offset == '0) |=> (rd_data == 8'h34));

    p_batt_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && id_mode && bus_offset == VBATT_OFFS) |=>
        (rd_data == {{(DATA_W-VCODE_W){1'b0}}, $past(batt_code)}));

    p_slot_upper_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && id_mode && region == RG_SLOT) |=> (rd_data[DATA_W-1:1] == '0));

    p_hold_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));

    p_outside_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !id_mode) |=> (rd_data == '0));

    p_unmapped_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && id_mode && region == RG_NONE) |=> (rd_data == '0));
endmodule

// File: tb/idwin_readback_test.sv
module idwin_readback_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        id_mode = 1'b0;
    logic [15:0] bus_offset = '0;
    logic        rd_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_data = '0;
    logic [15:0] ctrl_ext = '0, save_dev_id = '0, ctrl_main = '0;
    logic [15:0] io_ctrl = '0, rom_bank = '0, save_bank = '0;
    logic [5:0]  batt_code = '0, host_code = '0;
    logic [7:0]  rd_data;
    logic        ext_sram_sel;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    idwin_readback uut (
        .clk(clk), .rst_n(rst_n), .id_mode(id_mode), .bus_offset(bus_offset),
        .rd_en(rd_en), .wr_en(wr_en), .wr_data(wr_data),
        .ctrl_ext(ctrl_ext), .save_dev_id(save_dev_id), .ctrl_main(ctrl_main),
        .io_ctrl(io_ctrl), .rom_bank(rom_bank), .save_bank(save_bank),
        .batt_code(batt_code), .host_code(host_code),
        .rd_data(rd_data), .ext_sram_sel(ext_sram_sel)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic do_read(input logic [15:0] offs, output logic [7:0] data);
        @(negedge clk);
        bus_offset = offs;
        rd_en      = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        data  = rd_data;
    endtask

    task automatic do_write(input logic [15:0] offs, input logic [7:0] d);
        @(negedge clk);
        bus_offset = offs;
        wr_data    = d;
        wr_en      = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic t_reset;
        check("R9 rd_data after reset", 16'(rd_data), 16'h00);
    endtask

    task automatic t_signature;
        logic [7:0] d;
        logic [7:0] exp [5] = '{8'h34, 8'h16, 8'h96, 8'h24, 8'hF6};
        for (int i = 0; i < 5; i++) begin
            do_read(16'(i), d);
            check($sformatf("R1 signature byte %0d", i), 16'(d), 16'(exp[i]));
        end
    endtask

    task automatic t_voltage;
        logic [7:0] d;
        batt_code = 6'd0;  host_code = 6'd63;
        do_read(16'h0005, d); check("R2 battery code 0", 16'(d), 16'h00);
        do_read(16'h0006, d); check("R2 host code 63", 16'(d), 16'h3F);
        batt_code = 6'd63; host_code = 6'd37;
        do_read(16'h0005, d); check("R2 battery code 63", 16'(d), 16'h3F);
        do_read(16'h0006, d); check("R2 host code 37", 16'(d), 16'h25);
    endtask

    task automatic t_slots;
        logic [7:0]  d;
        logic [15:0] bases [6] = '{16'h8040, 16'h8050, 16'h8070, 16'h8080, 16'h8090, 16'h80A0};
        logic [15:0] vals  [6];
        ctrl_ext = 16'h0630; save_dev_id = 16'hA55A; ctrl_main = 16'h8E83;
        io_ctrl  = 16'h1F0F; rom_bank    = 16'h0001; save_bank = 16'h8000;
        vals = '{16'h0630, 16'hA55A, 16'h8E83, 16'h1F0F, 16'h0001, 16'h8000};
        for (int s = 0; s < 6; s++) begin
            for (int b = 0; b < 16; b++) begin
                do_read(bases[s] + 16'(b), d);
                // R3 bit value in data bit 0, R4 upper bits zero
                check($sformatf("R3/R4 slot %0h bit %0d", bases[s], b),
                      16'(d), {15'b0, vals[s][b]});
            end
        end
    endtask

    task automatic t_cache;
        logic [7:0] d;
        do_write(16'hC000, 8'hA1);
        do_write(16'hC3FF, 8'h5E);
        do_write(16'hC155, 8'h3C);
        do_read(16'hC000, d); check("R5 cache first byte", 16'(d), 16'hA1);
        do_read(16'hC3FF, d); check("R5 cache last byte", 16'(d), 16'h5E);
        do_read(16'hC155, d); check("R5 cache mid byte", 16'(d), 16'h3C);
        do_write(16'hC155, 8'hC3);
        do_read(16'hC155, d); check("R5 cache overwrite", 16'(d), 16'hC3);
    endtask

    task automatic t_hold;
        logic [7:0] d;
        do_read(16'h0002, d);
        check("R6 first value", 16'(d), 16'h96);
        bus_offset = 16'h0000;
        repeat (3) @(negedge clk);
        check("R6 hold while idle", 16'(rd_data), 16'h96);
        do_write(16'hC000, 8'h77);
        check("R6 hold across write", 16'(rd_data), 16'h96);
        do_read(16'hC000, d);
        check("R6 cache read after hold", 16'(d), 16'h77);
    endtask

    task automatic t_outside;
        logic [7:0] d;
        do_write(16'hC010, 8'h42);
        id_mode = 1'b0;
        @(negedge clk);
        check("R7 no access select", 16'(ext_sram_sel), 16'h0);
        bus_offset = 16'hC010; wr_data = 8'hEE; wr_en = 1'b1;
        #1 check("R7 write select", 16'(ext_sram_sel), 16'h1);
        @(negedge clk); wr_en = 1'b0;
        bus_offset = 16'h0000; rd_en = 1'b1;
        #1 check("R7 read select", 16'(ext_sram_sel), 16'h1);
        @(negedge clk); rd_en = 1'b0;
        check("R7 read outside mode", 16'(rd_data), 16'h00);
        id_mode = 1'b1;
        #1 check("R7 select low in mode", 16'(ext_sram_sel), 16'h0);
        do_read(16'hC010, d);
        check("R7 cache untouched", 16'(d), 16'h42);
    endtask

    task automatic t_unmapped;
        logic [7:0]  d;
        logic [15:0] offs [6] = '{16'h0007, 16'h8060, 16'h80B0, 16'hC400, 16'h4000, 16'h803F};
        for (int i = 0; i < 6; i++) begin
            do_read(16'h0000, d);
            do_read(offs[i], d);
            check($sformatf("R8 unmapped %0h", offs[i]), 16'(d), 16'h00);
        end
        do_write(16'hC000, 8'h11);
        do_write(16'hC400, 8'h99);
        do_write(16'h8000, 8'h98);
        do_write(16'h0000, 8'h97);
        do_read(16'hC000, d);
        check("R8 stray writes ignored", 16'(d), 16'h11);
    endtask

    initial begin
        #(20 * 200000);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        id_mode = 1'b1;
        t_signature();
        t_voltage();
        t_slots();
        t_cache();
        t_hold();
        t_outside();
        t_unmapped();
        repeat (2) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule